// File: doc/BRIEF.md
# Externally Synchronized Capture Timer

This block is an up-counter whose timebase is tied to one of three asynchronous event inputs. Each event input is first brought into the clock domain by a short flip-flop chain. A rising edge on the synchronized signal counts as one event, so an input that stays high acts only once. A select input chooses which of the three sources drives the counter. Select value 3 chooses none of them.

The mode input chooses between two ways of using the event. In sync mode the counter runs all the time: it wraps to zero after reaching the period value, and it jumps back to zero whenever an event arrives. In trigger mode the counter rests at zero until an event arrives. It then counts up to the period value, returns to zero and waits for the next event. When the enable input is low, the counter is held at zero and events are discarded. A registered period-match flag is high in the same cycles in which the count output shows the period value.

Top module: `ext_sync_timer`

## Requirements
- R1: While `rst` is high, `count` is 0 and `period_match` is 0 from the next clock edge on.
- R2: A rising edge on the selected event input takes effect on the third rising clock edge after the input goes high. An input that is held high produces only one event.
- R3: `src_sel` values 0, 1 and 2 pick `evt_in[0]`, `evt_in[1]` and `evt_in[2]`. Activity on an unselected input has no effect. `src_sel` = 3 selects no input.
- R4: In sync mode (`mode` = 0) the count rises by one on every clock edge. On the edge after it equals `period`, it goes to 0.
- R5: In sync mode an event sets `count` to 0 on the edge where the event takes effect. Counting then continues upward from 0.
- R6: In trigger mode (`mode` = 1), while no count is in progress, `count` is 0, even if the mode was just changed from sync with a nonzero count.
- R7: In trigger mode an event that arrives while the counter is at rest starts a count: `count` becomes 1 on the edge where the event takes effect, then rises by one per edge.
- R8: In trigger mode, on the edge after `count` equals `period`, `count` returns to 0 and stays there until the next event, which starts a fresh count.
- R9: In trigger mode an event that arrives while a count is in progress is ignored.
- R10: `period_match` is 1 exactly in the cycles where a counting or sync step leaves `count` equal to `period`. With `period` above 0 it lasts one cycle. In sync mode with `period` = 0, `count` stays 0 and `period_match` stays 1.
- R11: While `enable` is low, `count` and `period_match` are 0. An event that arrives while `enable` is low is lost and does not act later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Counter enable; when low, holds the counter at zero |
| mode | input | 1 | 0 = sync mode, 1 = trigger mode |
| src_sel | input | 2 | Event source select (0..2; 3 = none) |
| evt_in | input | 3 | Asynchronous event inputs |
| period | input | 16 | Period value the counter wraps at |
| count | output | 16 | Registered counter value |
| period_match | output | 1 | Registered flag, high when the count equals the period |

## Verification
The step and one-pulse properties assume that `period` does not change across the edge being checked. The trigger-mode idle property assumes that `mode` is only switched when the count may legally be discarded. The stimulus changes `period` and `mode` only at moments where the expected count follows from the requirements. For example, it switches to trigger mode and then checks only after the counter has come to rest. The event inputs are driven at the falling edge and held for whole cycles, so each edge the bench counts reaches the synchronizer at a known rising edge.

// File: rtl/est_pkg.sv
package est_pkg;

  typedef enum logic {
    EST_MODE_SYNC = 1'b0,
    EST_MODE_TRIG = 1'b1
  } est_mode_e;

endpackage

// File: rtl/est_edge_detect.sv
module est_edge_detect #(
  parameter int NUM_SRC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] raw_in,
  output logic [NUM_SRC-1:0] rise
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [PIPE_W-1:0] pipe_q;

    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[PIPE_W-2:0], raw_in[i]};
    end

    // Rising edge on the last synchronizer stage compared with the delayed copy
    assign rise[i] = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];

    // R2: a detected edge never lasts two cycles, so a held input acts once
    p_single_edge_r2: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end

endmodule

// File: rtl/est_src_select.sv
module est_src_select #(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_SRC-1:0] rise,
  output logic               evt
);

  always_comb begin
    evt = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) evt = rise[i];
    end
  end

endmodule

// File: rtl/est_count_core.sv
module est_count_core
  import est_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  est_mode_e        mode,
  input  logic             evt,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count_q,
  output logic             match_q
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_d;
  logic             match_d;
  logic             wrap;
  logic [CNT_W-1:0] step_val;
  logic             zero_period;

  assign wrap        = (count_q >= period);
  assign step_val    = wrap ? '0 : count_q + CNT_ONE;
  assign zero_period = (period == '0);

  always_comb begin
    cnt_d   = count_q;
    run_d   = run_q;
    match_d = 1'b0;
    if (!enable) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (mode == EST_MODE_SYNC) begin
      run_d   = 1'b0;
      cnt_d   = evt ? '0 : step_val;
      match_d = (cnt_d == period);
    end else if (run_q) begin
      cnt_d   = step_val;
      run_d   = !wrap;
      match_d = (step_val == period);
    end else if (evt) begin
      cnt_d   = zero_period ? '0 : CNT_ONE;
      run_d   = !zero_period;
      match_d = (cnt_d == period);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      run_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      count_q <= cnt_d;
      run_q   <= run_d;
      match_q <= match_d;
    end
  end

  // R1: reset clears the outputs
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (count_q == '0 && !match_q));

  // R11: disabled counter sits at zero
  p_disabled_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (count_q == '0 && !match_q));

  // R4: sync-mode step below the period
  p_sync_step_r4: assert property (@(posedge clk) disable iff (rst)
    (enable && mode == EST_MODE_SYNC && !evt && count_q < period)
    |=> count_q == $past(count_q) + CNT_ONE);

  // R5: sync-mode event zeroes the counter
  p_sync_evt_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (enable && mode == EST_MODE_SYNC && evt) |=> count_q == '0);

  // R6: idle trigger mode holds zero
  p_trig_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (enable && mode == EST_MODE_TRIG && !run_q && !evt) |=> count_q == '0);

  // R7: trigger start loads one and begins running
  p_trig_start_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && mode == EST_MODE_TRIG && !run_q && evt && !zero_period)
    |=> (count_q == CNT_ONE && run_q));

  // R10: match is a single-cycle pulse when the period is nonzero
  p_match_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (match_q && !zero_period) |=> (!match_q || period != $past(period)));

endmodule

// File: rtl/ext_sync_timer.sv
module ext_sync_timer
  import est_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_SRC     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               mode,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic [CNT_W-1:0]   period,
  output logic [CNT_W-1:0]   count,
  output logic               period_match
);

  logic [NUM_SRC-1:0] rise;
  logic               evt;
  est_mode_e          mode_e;

  assign mode_e = est_mode_e'(mode);

  est_edge_detect #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk   (clk),
    .rst   (rst),
    .raw_in(evt_in),
    .rise  (rise)
  );

  est_src_select #(
    .NUM_SRC(NUM_SRC),
    .SEL_W  (SEL_W)
  ) u_sel (
    .sel (src_sel),
    .rise(rise),
    .evt (evt)
  );

  est_count_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .mode   (mode_e),
    .evt    (evt),
    .period (period),
    .count_q(count),
    .match_q(period_match)
  );

endmodule

// File: tb/tb_ext_sync_timer.sv
`timescale 1ns/1ps
module tb_ext_sync_timer;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic        mode;
  logic [1:0]  src_sel;
  logic [2:0]  evt_in;
  logic [15:0] period;
  logic [15:0] count;
  logic        period_match;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ext_sync_timer dut (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .src_sel(src_sel),
    .evt_in(evt_in), .period(period), .count(count), .period_match(period_match)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; enable = 1'b1; mode = 1'b0; src_sel = 2'd0;
    evt_in = 3'b000; period = 16'd5;
    tick(3);
    check("R1 count", int'(count), 0);
    check("R1 match", int'(period_match), 0);
  endtask

  task automatic t_sync_wrap;
    rst = 1'b0;
    for (int i = 1; i <= 14; i++) begin
      tick(1);
      check("R4 count", int'(count), i % 6);
      check("R10 match", int'(period_match), ((i % 6) == 5) ? 1 : 0);
    end
  endtask

  task automatic t_sync_event;
    period = 16'd200;
    enable = 1'b0; tick(1);
    enable = 1'b1; tick(2);
    check("R11 restart", int'(count), 2);
    evt_in = 3'b001;
    tick(2);
    check("R2 not yet", int'(count), 4);
    tick(1);
    check("R5 zeroed", int'(count), 0);
    tick(4);
    check("R2 held once", int'(count), 4);
    evt_in = 3'b000;
    tick(3);
    check("R5 continues", int'(count), 7);
  endtask

  task automatic t_select;
    src_sel = 2'd1;
    enable = 1'b0; tick(1);
    enable = 1'b1; tick(2);
    evt_in = 3'b101;
    tick(4);
    evt_in = 3'b000;
    tick(2);
    check("R3 unselected ignored", int'(count), 8);
    evt_in = 3'b010;
    tick(3);
    check("R3 input1 selected", int'(count), 0);
    evt_in = 3'b000;
    tick(3);
    src_sel = 2'd3;
    evt_in = 3'b111;
    tick(4);
    evt_in = 3'b000;
    tick(3);
    check("R3 sel3 none", int'(count), 10);
    src_sel = 2'd2;
    evt_in = 3'b100;
    tick(3);
    check("R3 input2 selected", int'(count), 0);
    evt_in = 3'b000;
    tick(3);
    src_sel = 2'd0;
  endtask

  task automatic t_trigger;
    period = 16'd4;
    mode = 1'b1;
    tick(5);
    check("R6 idle count", int'(count), 0);
    check("R6 idle match", int'(period_match), 0);
    evt_in = 3'b001;
    tick(3);
    check("R7 start", int'(count), 1);
    tick(1); check("R7 count2", int'(count), 2);
    tick(1); check("R7 count3", int'(count), 3);
    tick(1);
    check("R10 trig count", int'(count), 4);
    check("R10 trig match", int'(period_match), 1);
    tick(1);
    check("R8 back to zero", int'(count), 0);
    check("R10 match drops", int'(period_match), 0);
    tick(4);
    check("R8 waits", int'(count), 0);
    evt_in = 3'b000;
    tick(3);
  endtask

  task automatic t_retrigger;
    period = 16'd10;
    evt_in = 3'b001; tick(1); evt_in = 3'b000; tick(2);
    check("R7 pulse start", int'(count), 1);
    evt_in = 3'b001; tick(1); evt_in = 3'b000; tick(2);
    check("R9 retrigger ignored", int'(count), 4);
    tick(6);
    check("R10 reach period", int'(count), 10);
    check("R10 match at period", int'(period_match), 1);
    tick(1);
    check("R8 returns", int'(count), 0);
    tick(2);
    evt_in = 3'b001; tick(1); evt_in = 3'b000; tick(2);
    check("R8 rearmed", int'(count), 1);
    tick(10);
    check("R8 ends again", int'(count), 0);
  endtask

  task automatic t_enable;
    enable = 1'b0;
    tick(1);
    evt_in = 3'b001; tick(1); evt_in = 3'b000;
    tick(4);
    check("R11 disabled count", int'(count), 0);
    check("R11 disabled match", int'(period_match), 0);
    enable = 1'b1;
    tick(4);
    check("R11 event lost", int'(count), 0);
    mode = 1'b0;
    enable = 1'b0;
    tick(2);
    check("R11 sync held", int'(count), 0);
    enable = 1'b1;
    tick(3);
    check("R11 sync resumes", int'(count), 3);
  endtask

  task automatic t_zero_period;
    period = 16'd0;
    tick(2);
    check("R10 p0 count", int'(count), 0);
    check("R10 p0 match", int'(period_match), 1);
    tick(1);
    check("R10 p0 match held", int'(period_match), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sync_wrap();
    t_sync_event();
    t_select();
    t_trigger();
    t_retrigger();
    t_enable();
    t_zero_period();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule